// File: doc/BRIEF.md
# Edge-Capturing Interrupt Cause Aggregator

This block collects a set of peripheral interrupt lines into a single summary interrupt. Each source line is first brought into the local clock domain by a short flop chain, then a rising-edge detector turns each low-to-high transition into a one-cycle event. Each event sets a bit in a cause register. A separate mask register decides which recorded causes may drive the summary output. A cause bit is recorded even while its mask bit is zero. This lets software see events that happened while a source was blocked, and clear them before it unblocks the source.

Software uses a small register port with an address, a read strobe, a write strobe, write data and read data. Two addresses are decoded: the cause register and the mask register. A cause bit is cleared by writing zero to its position. Writing one to a position leaves that bit as it is, so one write can clear a chosen subset of bits without a read-modify-write. The mask register is written and read as a plain value.

Top module: `irqagg_top`

## Requirements
- R1: After reset the cause register and the mask register both read as zero and `irq_o` is low.
- R2: A rising edge on `src_i[i]` sets cause bit i no more than three clock edges after the edge, whether mask bit i is 0 or 1.
- R3: A source held high records one event only. Once that cause bit is cleared it stays clear while the source remains high.
- R4: A write to address 0 (cause) clears each cause bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged.
- R5: A write to address 1 (mask) replaces the mask with the write data. Mask bit value 1 passes the source and 0 blocks it. The mask changes on no other event.
- R6: `irq_o` is high exactly when some bit position has both cause and mask equal to 1.
- R7: When a source edge sets a cause bit in the same cycle as a write that clears that bit, the bit ends up set.
- R8: While `rd_en_i` is high, `rd_data_o` returns the current contents of the addressed register (address 0 cause, address 1 mask), and reading changes nothing. While `rd_en_i` is low, `rd_data_o` is zero.
- R9: Writing zero to the mask and then zero to the cause register leaves `irq_o` low and the cause register zero.
- R10: A falling edge on a source does not set its cause bit.
- R11: Writes to addresses 2 and 3 change no register, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Peripheral interrupt lines, asynchronous to clk_i |
| addr_i | input | ADDR_W | Register address: 0 cause, 1 mask |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wr_data_i | input | NUM_SRC | Write data |
| rd_data_o | output | NUM_SRC | Read data, valid in the same cycle as the read strobe |
| irq_o | output | 1 | Summary interrupt |

## Verification
The vector walk applies pulse patterns under several masks. Some vectors have every pulsed bit masked off and some have only partial overlap. These show whether capture really ignores the mask while the summary honours it. Each vector then writes a selective keep-pattern to the cause register, which separates clear-on-zero from clear-on-one and from whole-register clears. Directed tests cover the following cases:
- a level held high, which separates edge capture from level capture;
- a falling edge;
- a source edge that lands in the same cycle as a clearing write;
- writes to undecoded addresses;
- the shutdown sequence of mask-zero then cause-zero.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Register address map; the bench and software both depend on it.
    localparam int unsigned ADDR_CAUSE = 0;
    localparam int unsigned ADDR_MASK  = 1;

endpackage

// File: rtl/irqagg_sync.sv
// Brings each source into the clock domain and emits a one-cycle pulse
// on every rising edge of the synchronized level.
module irqagg_sync #(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] rise_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_SRC-1:0] chain;
        logic [NUM_SRC-1:0]                  prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = src_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev     = st_q.chain[LAST];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.chain[LAST] & ~st_q.prev;

    // A pulse never lasts two cycles on the same bit: a level records once.
    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rise_o) & rise_o) == '0); // R3

endmodule

// File: rtl/irqagg_regs.sv
// Cause and mask storage with the software register port.
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic [NUM_SRC-1:0] cause_o,
    output logic [NUM_SRC-1:0] mask_o
);

    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(ADDR_CAUSE);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(ADDR_MASK);

    typedef struct packed {
        logic [NUM_SRC-1:0] cause;
        logic [NUM_SRC-1:0] mask;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic               sel_cause;
    logic               sel_mask;
    logic [NUM_SRC-1:0] clr_bits;

    always_comb begin
        sel_cause = (addr_i == A_CAUSE);
        sel_mask  = (addr_i == A_MASK);
        clr_bits  = (wr_en_i && sel_cause) ? ~wr_data_i : '0;

        st_d       = st_q;
        // An edge in the same cycle as a clear keeps the bit set.
        st_d.cause = (st_q.cause & ~clr_bits) | rise_i;
        if (wr_en_i && sel_mask) begin
            st_d.mask = wr_data_i;
        end

        rd_data_o = '0;
        if (rd_en_i) begin
            if (sel_cause) begin
                rd_data_o = st_q.cause;
            end else if (sel_mask) begin
                rd_data_o = st_q.mask;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;

    AST_EDGE_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i != '0) |=> ((cause_o & $past(rise_i)) == $past(rise_i))); // R2
    AST_SET_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_o & ~$past(cause_o) & ~$past(rise_i)) == '0); // R10
    AST_CLEAR_NEEDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && addr_i == A_CAUSE) |=> (($past(cause_o) & ~cause_o) == '0)); // R4
    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && addr_i == A_MASK) |=> $stable(mask_o)); // R5

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] cause;
    logic [NUM_SRC-1:0] mask;

    irqagg_sync #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .rise_o (rise)
    );

    irqagg_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .cause_o   (cause),
        .mask_o    (mask)
    );

    assign irq_o = |(cause & mask);

    // Clearing the mask silences the output on the very next cycle.
    AST_QUIET_AFTER_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_W'(irqagg_pkg::ADDR_MASK) && wr_data_i == '0)
        |=> !irq_o); // R9

endmodule

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;

    localparam int unsigned N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic [1:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irqagg_top u_irqagg_top (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wr_data_i(wdata),
        .rd_data_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] pulse;
        logic [N-1:0] keep;
        logic         exp_irq;
        logic [N-1:0] exp_after;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 32'h0000_0001},
        '{32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000},
        '{32'h0000_00F0, 32'h0000_000F, 32'h0000_0005, 1'b0, 32'h0000_0005},
        '{32'h0000_0010, 32'h0000_0030, 32'hFFFF_FFEF, 1'b1, 32'h0000_0020},
        '{32'hAAAA_AAAA, 32'h5555_5555, 32'hAAAA_AAAA, 1'b0, 32'h0000_0000},
        '{32'h0000_FFFF, 32'hFFFF_0001, 32'hFFFF_0000, 1'b1, 32'hFFFF_0000}
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(input logic [N-1:0] p);
        @(negedge clk);
        src = src | p;
        wait_cycles(2);
        src = src & ~p;
        wait_cycles(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] rv, rv2;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);

        // R1: reset state
        reg_read(2'd0, rv); check("R1 cause", rv, '0);
        reg_read(2'd1, rv); check("R1 mask", rv, '0);
        check("R1 irq", N'(irq), '0);

        // Vector walk: R2, R4, R5, R6
        for (int i = 0; i < NV; i++) begin
            reg_write(2'd0, '0);
            reg_write(2'd1, VECS[i].mask);
            reg_read(2'd1, rv); check("R5 mask readback", rv, VECS[i].mask);
            pulse_src(VECS[i].pulse);
            reg_read(2'd0, rv); check("R2 cause captured", rv, VECS[i].pulse);
            #1 check("R6 irq", N'(irq), N'(VECS[i].exp_irq));
            reg_write(2'd0, VECS[i].keep);
            reg_read(2'd0, rv); check("R4 selective clear", rv, VECS[i].exp_after);
            #1 check("R6 irq after clear", N'(irq), N'(|(VECS[i].exp_after & VECS[i].mask)));
        end
        reg_write(2'd0, '0);
        reg_write(2'd1, '0);

        // R3: held level records once
        @(negedge clk); src[3] = 1'b1;
        wait_cycles(5);
        reg_read(2'd0, rv); check("R3 level captured", rv, 32'h8);
        reg_write(2'd0, '0);
        wait_cycles(5);
        reg_read(2'd0, rv); check("R3 no re-capture while high", rv, '0);

        // R10: falling edge does nothing
        @(negedge clk); src[3] = 1'b0;
        wait_cycles(5);
        reg_read(2'd0, rv); check("R10 falling edge", rv, '0);

        // R7: edge coincides with clearing write (set lands on third edge)
        @(negedge clk); src[7] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 2'd0; wdata = '0; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        reg_read(2'd0, rv); check("R7 edge beats clear", rv, 32'h80);
        @(negedge clk); src[7] = 1'b0;

        // R8: reads are side-effect free; strobe low returns zero
        reg_read(2'd0, rv);
        reg_read(2'd0, rv2); check("R8 repeat read", rv2, rv);
        @(negedge clk); addr = 2'd0; rd_en = 1'b0;
        #1 check("R8 no strobe zero", rdata, '0);

        // R11: undecoded addresses
        reg_write(2'd1, 32'h0000_00FF);
        reg_write(2'd2, '0);
        reg_write(2'd3, '0);
        reg_read(2'd0, rv); check("R11 cause untouched", rv, 32'h80);
        reg_read(2'd1, rv); check("R11 mask untouched", rv, 32'h0000_00FF);
        reg_read(2'd3, rv); check("R11 read undecoded", rv, '0);
        #1 check("R6 irq masked-in", N'(irq), 32'h1);

        // R9: shutdown sequence
        reg_write(2'd1, '0);
        #1 check("R9 irq after mask zero", N'(irq), '0);
        reg_write(2'd0, '0);
        reg_read(2'd0, rv); check("R9 cause zero", rv, '0);
        #1 check("R9 irq quiet", N'(irq), '0);

        finish_run();
    end

endmodule